// File: doc/BRIEF.md
# RTC Block Transfer Sequencer

This block drives a multi-byte register transfer with a real-time-clock chip on a two-wire serial bus. It does not toggle the bus itself. It sits above a byte engine that handles the bus timing, and hands that engine one command at a time: bus START, bus STOP, write a byte, or read a byte. The block walks the engine through the complete register-access sequence. A requester supplies a start register address, a byte count and a direction. Write bytes enter through a valid/ready port, and read bytes leave on a valid-strobed port. When the transfer ends, the block raises a one-cycle completion pulse together with a pass/fail flag.

A write sends the device byte with its direction bit clear, then the register address, then the payload, and then STOP. A read first sets the register pointer the same way. It then issues a repeated START, sends the device byte with its direction bit set, and clocks in the requested number of bytes. Every read byte is acknowledged except the last one. If the device fails to acknowledge any byte the block sends, the transfer stops early. STOP is still issued, and failure is reported.

Top module: `rtc_xfer_seq`

## Requirements
- R1: After reset, and whenever no transfer is in progress, `reqReady` is 1 while `cmdValid`, `wrReady`, `rdValid` and `done` are 0.
- R2: A write transfer issues, in this order: START, WRITE of the device byte (7-bit address `DEV_ADDR` followed by a 0 bit, 8'hD0 by default), WRITE of the register address, one WRITE per payload byte in arrival order, and STOP. Command codes on `cmdOp` are 0 = START, 1 = STOP, 2 = WRITE, 3 = READ.
- R3: A read transfer with a nonzero count issues START, WRITE of the device byte with bit 0 clear, WRITE of the register address, a second START, WRITE of the device byte with bit 0 set (8'hD1 by default), exactly `reqCount` READ commands, and STOP.
- R4: On each READ command, `cmdAck` is 1 (acknowledge) for every byte except the last one of the transfer, where it is 0 (no acknowledge).
- R5: If the engine reports `rspAck` = 0 for any WRITE command, no further WRITE, READ or START follows. The next command is STOP, `ok` is 0 at completion, and no later payload byte is taken from the write port.
- R6: With a count of zero, in either direction, only START, the device byte, the register address and STOP are issued. `ok` is 1 when both bytes were acknowledged.
- R7: Each byte returned by a READ appears on `rdData` with a single-cycle `rdValid`, in the cycle after the engine's response.
- R8: `done` is a single-cycle pulse in the cycle after the engine answers STOP. `ok` holds the result at that time, and `reqReady` is 1 in the same cycle.
- R9: A request is taken only while `reqReady` is 1. A `reqValid` raised during a transfer neither changes the commands issued nor starts a further transfer.
- R10: Only one command is outstanding at a time. `cmdValid` stays high with a stable `cmdOp` until `cmdReady`, and the next command waits for `rspValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| reqValid | input | 1 | Transfer request strobe |
| reqReady | output | 1 | Block idle, request can be taken |
| reqRead | input | 1 | 1 = read transfer, 0 = write transfer |
| reqAddr | input | 8 | Starting register address |
| reqCount | input | CNT_W | Number of payload bytes |
| wrValid | input | 1 | Write payload byte available |
| wrReady | output | 1 | Block takes the write payload byte |
| wrData | input | 8 | Write payload byte |
| rdValid | output | 1 | Read byte strobe |
| rdData | output | 8 | Read byte |
| cmdValid | output | 1 | Command offered to the byte engine |
| cmdReady | input | 1 | Engine takes the command |
| cmdOp | output | 2 | 0 START, 1 STOP, 2 WRITE, 3 READ |
| cmdData | output | 8 | Byte to send on WRITE |
| cmdAck | output | 1 | Acknowledge to send after a READ byte |
| rspValid | input | 1 | Engine finished the outstanding command |
| rspAck | input | 1 | Device acknowledged the written byte |
| rspData | input | 8 | Byte received on READ |
| done | output | 1 | Transfer complete pulse |
| ok | output | 1 | Transfer result, 1 = success |

## Verification
The engine model in the bench answers each command a selectable number of cycles after taking it. Both `rdValid` and `done` are due exactly one clock after that answer. Every command is therefore checked at the falling edge where it is first offered. The bench then arms a one-shot expectation at the falling edge where it drives the response, and checks it at the very next falling edge, so a strobe that comes early, late, or not at all is reported. Write payload counts and the empty scoreboard are checked after each completion pulse, which confirms that aborted and busy-time requests left no trace.

// File: rtl/rtc_xfer_pkg.sv
package rtc_xfer_pkg;

  localparam int BYTE_W = 8;

  typedef enum logic [1:0] {
    OP_START = 2'd0,
    OP_STOP  = 2'd1,
    OP_WRITE = 2'd2,
    OP_READ  = 2'd3
  } op_e;

  typedef enum logic [2:0] {
    ST_START1,
    ST_DEVW,
    ST_REG,
    ST_WDATA,
    ST_START2,
    ST_DEVR,
    ST_RDATA,
    ST_STOP
  } step_e;

  typedef enum logic [1:0] {
    PH_IDLE,
    PH_FETCH,
    PH_ISSUE,
    PH_WAIT
  } phase_e;

  // strobes from control to datapath
  typedef struct packed {
    logic loadReq;
    logic loadWr;
    logic decCount;
    logic capRd;
    logic setFail;
  } dpCtl_t;

endpackage

// File: rtl/rtc_xfer_datapath.sv
module rtc_xfer_datapath
  import rtc_xfer_pkg::*;
#(
  parameter int          CNT_W    = 8,
  parameter logic [6:0]  DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpCtl_t            ctl,
  input  step_e             step,
  input  logic              reqRead,
  input  logic [BYTE_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic [BYTE_W-1:0] wrData,
  input  logic [BYTE_W-1:0] rspData,
  output logic              isRead,
  output logic              countZero,
  output logic              countLast,
  output logic [BYTE_W-1:0] cmdData,
  output logic              cmdAck,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData,
  output logic              ok
);

  localparam logic [BYTE_W-1:0] DEV_WR = {DEV_ADDR, 1'b0};
  localparam logic [BYTE_W-1:0] DEV_RD = {DEV_ADDR, 1'b1};

  logic [BYTE_W-1:0] addrQ;
  logic [BYTE_W-1:0] dataQ;
  logic [CNT_W-1:0]  countQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      isRead  <= 1'b0;
      addrQ   <= '0;
      dataQ   <= '0;
      countQ  <= '0;
      rdValid <= 1'b0;
      rdData  <= '0;
      ok      <= 1'b0;
    end else begin
      rdValid <= ctl.capRd;
      if (ctl.loadReq) begin
        isRead <= reqRead;
        addrQ  <= reqAddr;
        countQ <= reqCount;
        ok     <= 1'b1;
      end
      if (ctl.loadWr)   dataQ  <= wrData;
      if (ctl.decCount) countQ <= countQ - 1'b1;
      if (ctl.capRd)    rdData <= rspData;
      if (ctl.setFail)  ok     <= 1'b0;
    end
  end

  assign countZero = (countQ == '0);
  assign countLast = (countQ == CNT_W'(1));
  assign cmdAck    = !countLast;

  always_comb begin
    case (step)
      ST_DEVW:  cmdData = DEV_WR;
      ST_REG:   cmdData = addrQ;
      ST_WDATA: cmdData = dataQ;
      ST_DEVR:  cmdData = DEV_RD;
      default:  cmdData = '0;
    endcase
  end

endmodule

// File: rtl/rtc_xfer_control.sv
module rtc_xfer_control
  import rtc_xfer_pkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   reqValid,
  input  logic   wrValid,
  input  logic   cmdReady,
  input  logic   rspValid,
  input  logic   rspAck,
  input  logic   isRead,
  input  logic   countZero,
  input  logic   countLast,
  output logic   reqReady,
  output logic   wrReady,
  output logic   cmdValid,
  output op_e    cmdOp,
  output step_e  step,
  output dpCtl_t ctl,
  output logic   done
);

  phase_e phase, nextPhase;
  step_e  nextStep;
  logic   finish;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= PH_IDLE;
      step  <= ST_START1;
      done  <= 1'b0;
    end else begin
      phase <= nextPhase;
      step  <= nextStep;
      done  <= finish;
    end
  end

  assign reqReady = (phase == PH_IDLE);
  assign wrReady  = (phase == PH_FETCH);
  assign cmdValid = (phase == PH_ISSUE);

  always_comb begin
    case (step)
      ST_START1, ST_START2: cmdOp = OP_START;
      ST_STOP:              cmdOp = OP_STOP;
      ST_RDATA:             cmdOp = OP_READ;
      default:              cmdOp = OP_WRITE;
    endcase
  end

  always_comb begin
    ctl       = '0;
    nextPhase = phase;
    nextStep  = step;
    finish    = 1'b0;
    case (phase)
      PH_IDLE: if (reqValid) begin
        ctl.loadReq = 1'b1;
        nextStep    = ST_START1;
        nextPhase   = PH_ISSUE;
      end
      PH_FETCH: if (wrValid) begin
        ctl.loadWr = 1'b1;
        nextPhase  = PH_ISSUE;
      end
      PH_ISSUE: if (cmdReady) nextPhase = PH_WAIT;
      PH_WAIT: if (rspValid) begin
        nextPhase = PH_ISSUE;
        case (step)
          ST_START1: nextStep = ST_DEVW;
          ST_DEVW: begin
            ctl.setFail = !rspAck;
            nextStep    = rspAck ? ST_REG : ST_STOP;
          end
          ST_REG: begin
            ctl.setFail = !rspAck;
            if (!rspAck || countZero) nextStep = ST_STOP;
            else if (isRead)          nextStep = ST_START2;
            else begin
              nextStep  = ST_WDATA;
              nextPhase = PH_FETCH;
            end
          end
          ST_WDATA: begin
            ctl.decCount = 1'b1;
            ctl.setFail  = !rspAck;
            if (!rspAck || countLast) nextStep = ST_STOP;
            else nextPhase = PH_FETCH;
          end
          ST_START2: nextStep = ST_DEVR;
          ST_DEVR: begin
            ctl.setFail = !rspAck;
            nextStep    = rspAck ? ST_RDATA : ST_STOP;
          end
          ST_RDATA: begin
            ctl.capRd    = 1'b1;
            ctl.decCount = 1'b1;
            if (countLast) nextStep = ST_STOP;
          end
          default: begin
            nextPhase = PH_IDLE;
            finish    = 1'b1;
          end
        endcase
      end
      default: nextPhase = PH_IDLE;
    endcase
  end

  // R8: completion strobe lasts one cycle
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R8: block is ready for a new request when completion is reported
  a_r8_done_idle: assert property (@(posedge clk) disable iff (!rstN)
    done |-> reqReady);

  // R10: an offered command is held until taken
  a_r10_cmd_hold: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdOp)));

endmodule

// File: rtl/rtc_xfer_seq.sv
module rtc_xfer_seq
  import rtc_xfer_pkg::*;
#(
  parameter int         CNT_W    = 8,
  parameter logic [6:0] DEV_ADDR = 7'h68
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqRead,
  input  logic [BYTE_W-1:0] reqAddr,
  input  logic [CNT_W-1:0]  reqCount,
  input  logic              wrValid,
  output logic              wrReady,
  input  logic [BYTE_W-1:0] wrData,
  output logic              rdValid,
  output logic [BYTE_W-1:0] rdData,
  output logic              cmdValid,
  input  logic              cmdReady,
  output logic [1:0]        cmdOp,
  output logic [BYTE_W-1:0] cmdData,
  output logic              cmdAck,
  input  logic              rspValid,
  input  logic              rspAck,
  input  logic [BYTE_W-1:0] rspData,
  output logic              done,
  output logic              ok
);

  dpCtl_t ctl;
  step_e  step;
  op_e    opSel;
  logic   isRead, countZero, countLast;

  rtc_xfer_control u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .wrValid(wrValid),
    .cmdReady(cmdReady), .rspValid(rspValid), .rspAck(rspAck),
    .isRead(isRead), .countZero(countZero), .countLast(countLast),
    .reqReady(reqReady), .wrReady(wrReady), .cmdValid(cmdValid),
    .cmdOp(opSel), .step(step), .ctl(ctl), .done(done)
  );

  rtc_xfer_datapath #(.CNT_W(CNT_W), .DEV_ADDR(DEV_ADDR)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .step(step),
    .reqRead(reqRead), .reqAddr(reqAddr), .reqCount(reqCount),
    .wrData(wrData), .rspData(rspData), .isRead(isRead),
    .countZero(countZero), .countLast(countLast), .cmdData(cmdData),
    .cmdAck(cmdAck), .rdValid(rdValid), .rdData(rdData), .ok(ok)
  );

  assign cmdOp = opSel;

  // R7: a read strobe never coincides with completion
  a_r7_rd_not_done: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> !done);

endmodule

// File: tb/rtc_xfer_seq_bench.sv
`timescale 1ns/1ps
module rtc_xfer_seq_bench;

  localparam logic [7:0] DW = 8'hD0;
  localparam logic [7:0] DR = 8'hD1;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqRead = 0;
  logic [7:0] reqAddr = 0, reqCount = 0;
  logic wrValid = 0; logic [7:0] wrData = 0;
  logic cmdReady = 1, rspValid = 0, rspAck = 0; logic [7:0] rspData = 0;
  logic reqReady, wrReady, rdValid, cmdValid, cmdAck, done, ok;
  logic [7:0] rdData, cmdData; logic [1:0] cmdOp;

  always #4 clk = ~clk;

  rtc_xfer_seq u_rtc_xfer_seq (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqRead(reqRead), .reqAddr(reqAddr), .reqCount(reqCount),
    .wrValid(wrValid), .wrReady(wrReady), .wrData(wrData),
    .rdValid(rdValid), .rdData(rdData), .cmdValid(cmdValid),
    .cmdReady(cmdReady), .cmdOp(cmdOp), .cmdData(cmdData), .cmdAck(cmdAck),
    .rspValid(rspValid), .rspAck(rspAck), .rspData(rspData),
    .done(done), .ok(ok)
  );

  typedef struct {
    logic [1:0] op; logic [7:0] data; logic ack;
    logic rAck; logic [7:0] rData; int tag;
  } item_t;

  item_t expQ[$];
  logic [7:0] wrQ[$];
  int checks = 0, errors = 0;
  int lat = 1, wrTaken = 0;
  logic expOk = 0, doneSeen = 0, monOn = 0;
  logic pending = 0, expDone = 0, expRd = 0, wrAcc = 0;
  int delay = 0;
  item_t cur;

  task automatic check(input bit cond, input string req, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [1:0] op, input logic [7:0] d, input logic a,
                      input logic ra, input logic [7:0] rd, input int tag);
    item_t it;
    it.op = op; it.data = d; it.ack = a; it.rAck = ra; it.rData = rd; it.tag = tag;
    expQ.push_back(it);
  endtask

  // scoreboard monitor and byte-engine model
  initial begin
    forever begin
      @(negedge clk);
      if (monOn) begin
        if (expDone) begin
          check(done === 1'b1, "R8 done timing", done, 1);
          check(reqReady === 1'b1, "R8 ready with done", reqReady, 1);
          check(ok === expOk, "R5/R6 ok result", ok, expOk);
          doneSeen = 1;
        end else if (done) check(0, "R8 unexpected done", 1, 0);
        if (expRd) check(rdValid === 1'b1 && rdData === cur.rData, "R7 read byte", {rdValid, rdData}, {1'b1, cur.rData});
        else if (rdValid) check(0, "R7 unexpected rdValid", 1, 0);
        expDone = 0; expRd = 0;
        if (wrAcc) begin void'(wrQ.pop_front()); wrAcc = 0; end
        rspValid = 0;
        if (pending) begin
          if (delay == 0) begin
            rspValid = 1; rspAck = cur.rAck; rspData = cur.rData; pending = 0;
            if (cur.op == 2'd1) expDone = 1;
            if (cur.op == 2'd3) expRd = 1;
          end else delay--;
        end
        if (cmdValid) begin
          if (pending || rspValid) check(0, "R10 command while outstanding", 1, 0);
          else if (expQ.size() == 0) check(0, "R9 unexpected command", cmdOp, 0);
          else begin
            cur = expQ.pop_front();
            check(cmdOp === cur.op, $sformatf("R%0d command op", cur.tag), cmdOp, cur.op);
            if (cur.op == 2'd2) check(cmdData === cur.data, $sformatf("R%0d write byte", cur.tag), cmdData, cur.data);
            if (cur.op == 2'd3) check(cmdAck === cur.ack, "R4 read acknowledge", cmdAck, cur.ack);
            pending = 1; delay = lat;
          end
        end
        wrValid = (wrQ.size() > 0);
        wrData  = wrValid ? wrQ[0] : 8'h00;
        if (wrReady && wrValid) begin wrAcc = 1; wrTaken++; end
      end
    end
  end

  // driver: builds the expected command stream, then launches the request
  task automatic runTxn(input bit rd, input logic [7:0] addr, input int cnt,
                        input int nackAt, input int latency, input bit disturb);
    bit live; int taken, cyc;
    lat = latency; live = 1; taken = 0; wrTaken = 0; doneSeen = 0;
    push(2'd0, 0, 0, 1, 0, rd ? 3 : 2);
    push(2'd2, DW, 0, nackAt != 0, 0, rd ? 3 : 2);
    if (nackAt == 0) live = 0;
    if (live) begin
      push(2'd2, addr, 0, nackAt != 1, 0, rd ? 3 : 2);
      if (nackAt == 1) live = 0;
    end
    if (live && !rd) begin
      for (int i = 0; i < cnt && live; i++) begin
        logic [7:0] b = 8'h21 + 8'(i * 37);
        wrQ.push_back(b);
        push(2'd2, b, 0, nackAt != 2 + i, 0, 2);
        taken = i + 1;
        if (nackAt == 2 + i) begin
          live = 0;
          for (int j = i + 1; j < cnt; j++) wrQ.push_back(8'hEE);
        end
      end
    end
    if (live && rd && cnt > 0) begin
      push(2'd0, 0, 0, 1, 0, 3);
      push(2'd2, DR, 0, nackAt != 2, 0, 3);
      if (nackAt == 2) live = 0;
      for (int i = 0; i < cnt && live; i++)
        push(2'd3, 0, (i != cnt - 1), 1, (8'h5A + 8'(i * 19)) ^ addr, 3);
    end
    push(2'd1, 0, 0, 1, 0, 5);
    expOk = live;
    @(negedge clk); #1;
    reqRead = rd; reqAddr = addr; reqCount = 8'(cnt); reqValid = 1;
    @(negedge clk); #1;
    reqValid = 0;
    cyc = 0;
    while (!doneSeen && cyc < 3000) begin
      @(negedge clk); #1; cyc++;
      if (disturb && cyc == 6) begin
        reqRead = !rd; reqAddr = 8'h77; reqCount = 8'd9; reqValid = 1;
      end
      if (disturb && cyc == 9) begin
        check(reqReady === 1'b0, "R9 not ready while busy", reqReady, 0);
        reqValid = 0;
      end
    end
    if (!doneSeen) check(0, "watchdog expired", cyc, 0);
    repeat (3) @(negedge clk);
    #1;
    check(expQ.size() == 0, "R9 scoreboard empty", expQ.size(), 0);
    if (!rd) check(wrTaken == taken, "R5 write bytes taken", wrTaken, taken);
    check(reqReady === 1'b1 && cmdValid === 1'b0 && wrReady === 1'b0, "R1 idle after transfer",
          {reqReady, cmdValid, wrReady}, 3'b100);
    expQ.delete(); wrQ.delete();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(reqReady === 1'b1, "R1 reqReady in reset", reqReady, 1);
    check(cmdValid === 1'b0 && wrReady === 1'b0, "R1 no command in reset", {cmdValid, wrReady}, 0);
    check(done === 1'b0 && rdValid === 1'b0, "R1 no strobes in reset", {done, rdValid}, 0);
    rstN = 1; monOn = 1;
    repeat (2) @(negedge clk);
    runTxn(0, 8'h10, 3, -1, 1, 0);   // R2 plain write
    runTxn(1, 8'h05, 4, -1, 2, 0);   // R3 R4 R7 read
    runTxn(1, 8'h08, 1, -1, 0, 0);   // R4 single-byte read: NAK only
    runTxn(1, 8'h02, 0, -1, 1, 0);   // R6 read with zero count
    runTxn(0, 8'h03, 0, -1, 0, 0);   // R6 write with zero count
    runTxn(0, 8'h20, 3, 0, 1, 0);    // R5 device byte refused
    runTxn(0, 8'h21, 4, 3, 2, 0);    // R5 second payload byte refused
    runTxn(1, 8'h30, 2, 1, 1, 0);    // R5 register address refused
    runTxn(1, 8'h31, 2, 2, 0, 0);    // R5 read device byte refused
    runTxn(0, 8'h40, 5, -1, 3, 1);   // R9 R10 busy request ignored
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule